// File: doc/BRIEF.md
# Page Remap and Tier Swap Unit

This unit sits between a stream of host page accesses and a device memory made of two tiers: a small fast tier and a larger slow tier. It keeps a page-granular remap table that the host never sees. Each host access is looked up in that table, turned into a tier select and a tier-local address, and issued on the memory side. Accesses leave in the order they arrive, one per cycle at full rate.

A profiler outside the unit offers a pair of pages: one it considers hot and one it considers cold. If the hot page sits in the slow tier and the cold page sits in the fast tier, the unit exchanges their data. It does this through a block-copy request port and a staging buffer, in three copies. It then rewrites both table entries in one cycle. Any other pair is dropped at once.

Host accesses to either page of a pair in progress are held off until the table update lands. Accesses to all other pages keep flowing. A token bucket bounds how often a swap may begin.

Top module: `page_swap_unit`

## Requirements
- R1: After reset every page maps to the frame with its own number. Frames below FAST_PAGES belong to the fast tier and the rest belong to the slow tier.
- R2: An access accepted on one clock edge appears on the memory outputs after the third edge from that one. Accesses appear in acceptance order. The outputs are mem_slow_o = 1 for a slow-tier frame, and mem_addr_o = {tier-local frame, offset}, where the tier-local frame of a slow frame is the frame minus FAST_PAGES.
- R3: A pair is exchanged only when the hot page maps to a slow frame and the cold page maps to a fast frame. Any other pair, including a pair already placed as desired, is discarded without a copy request, and swp_ready_o is high again two cycles after acceptance.
- R4: A swap issues three copies in this order: hot frame to staging, cold frame to hot frame, staging to cold frame. On the copy endpoints, a frame f is coded as {1'b0, f} and the staging buffer is coded as {1'b1, zeros}.
- R5: After the third copy completes, the hot page maps to the cold page's old frame and the cold page maps to the hot page's old frame. Both entries change in the same cycle, and every later access uses the new mapping.
- R6: From the acceptance of an eligible pair until its table update, req_ready_o is low for either page of the pair. It is high for every other page.
- R7: A token bucket starts empty at reset, gains one token every REFILL_CYCLES cycles, and holds at most TOKEN_MAX tokens. A swap starts copying only by consuming a token. Discarded pairs consume none.
- R8: cp_req_o, cp_src_o and cp_dst_o stay stable from the moment a copy is requested until the cycle in which cp_done_i is seen.
- R9: The first copy of a swap does not begin while an access to either page of the pair is still in the lookup or translation stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host access valid |
| req_ready_o | output | 1 | Host access accepted when high with valid |
| req_page_i | input | PAGE_W | Host page number |
| req_off_i | input | OFF_W | Offset within the page |
| mem_valid_o | output | 1 | Memory access issued |
| mem_slow_o | output | 1 | 1 selects the slow tier |
| mem_addr_o | output | PAGE_W+OFF_W | Tier-local frame and offset |
| swp_valid_i | input | 1 | Hot/cold pair offered |
| swp_ready_o | output | 1 | Pair accepted when high with valid |
| swp_hot_i | input | PAGE_W | Hot page |
| swp_cold_i | input | PAGE_W | Cold page |
| cp_req_o | output | 1 | Block copy requested |
| cp_src_o | output | PAGE_W+1 | Copy source endpoint |
| cp_dst_o | output | PAGE_W+1 | Copy destination endpoint |
| cp_done_i | input | 1 | Current copy finished (one-cycle pulse) |

## Verification
The hardest case to reach is a host access to a page whose swap is partly done. Holding it back must delay it past the table update, while accesses to other pages still pass. The bench sets this up by offering an eligible pair and waiting until the copy port shows the first request. While the copy model stretches each copy over several cycles, it then drives accesses to both pair pages and to a bystander page. The token-cap case is reached by letting the bucket fill over several refill periods and then offering three eligible pairs just after a refill edge. Only the third should have to wait for the next refill.

// File: rtl/psu_pkg.sv
package psu_pkg;

  typedef enum logic [2:0] {
    SW_IDLE,
    SW_CHECK,
    SW_WAIT,
    SW_CP_HOT,
    SW_CP_COLD,
    SW_CP_STG,
    SW_COMMIT
  } swap_state_e;

endpackage

// File: rtl/psu_remap_table.sv
module psu_remap_table #(
  parameter int NUM_PAGES = 8,
  parameter int PAGE_W    = 3,
  parameter int RD_PORTS  = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [RD_PORTS-1:0][PAGE_W-1:0]  rd_page_i,
  output logic [RD_PORTS-1:0][PAGE_W-1:0]  rd_frame_o,
  input  logic                             wr_en_i,
  input  logic [PAGE_W-1:0]                wr_page_a_i,
  input  logic [PAGE_W-1:0]                wr_frame_a_i,
  input  logic [PAGE_W-1:0]                wr_page_b_i,
  input  logic [PAGE_W-1:0]                wr_frame_b_i
);

  logic [PAGE_W-1:0] map_q [NUM_PAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PAGES; i++) map_q[i] <= PAGE_W'(i);
    end else if (wr_en_i) begin
      map_q[wr_page_a_i] <= wr_frame_a_i;
      map_q[wr_page_b_i] <= wr_frame_b_i;
    end
  end

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
    assign rd_frame_o[g] = map_q[rd_page_i[g]];
  end

  AST_PAIR_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> wr_page_a_i != wr_page_b_i); // R5

  AST_FRAMES_EXCHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_frame_a_i == map_q[wr_page_b_i]) && (wr_frame_b_i == map_q[wr_page_a_i])); // R5

endmodule

// File: rtl/psu_req_pipe.sv
module psu_req_pipe #(
  parameter int PAGE_W     = 3,
  parameter int OFF_W      = 6,
  parameter int FAST_PAGES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    acc_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic [OFF_W-1:0]        off_i,
  output logic                    lk_vld_o,
  output logic [PAGE_W-1:0]       lk_page_o,
  input  logic [PAGE_W-1:0]       lk_frame_i,
  output logic                    tr_vld_o,
  output logic [PAGE_W-1:0]       tr_page_o,
  output logic                    mem_valid_o,
  output logic                    mem_slow_o,
  output logic [PAGE_W+OFF_W-1:0] mem_addr_o
);

  localparam logic [PAGE_W-1:0] FAST_F = PAGE_W'(FAST_PAGES);

  // lookup stage
  logic              lk_vld_q;
  logic [PAGE_W-1:0] lk_page_q;
  logic [OFF_W-1:0]  lk_off_q;
  // translation stage
  logic              tr_vld_q;
  logic [PAGE_W-1:0] tr_page_q, tr_frame_q;
  logic [OFF_W-1:0]  tr_off_q;

  logic              tr_slow;
  logic [PAGE_W-1:0] tr_local;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_vld_q   <= 1'b0;
      lk_page_q  <= '0;
      lk_off_q   <= '0;
      tr_vld_q   <= 1'b0;
      tr_page_q  <= '0;
      tr_frame_q <= '0;
      tr_off_q   <= '0;
      mem_valid_o <= 1'b0;
      mem_slow_o  <= 1'b0;
      mem_addr_o  <= '0;
    end else begin
      lk_vld_q <= acc_i;
      if (acc_i) begin
        lk_page_q <= page_i;
        lk_off_q  <= off_i;
      end
      tr_vld_q <= lk_vld_q;
      if (lk_vld_q) begin
        tr_page_q  <= lk_page_q;
        tr_frame_q <= lk_frame_i;
        tr_off_q   <= lk_off_q;
      end
      mem_valid_o <= tr_vld_q;
      if (tr_vld_q) begin
        mem_slow_o <= tr_slow;
        mem_addr_o <= {tr_local, tr_off_q};
      end
    end
  end

  always_comb begin
    tr_slow  = tr_frame_q >= FAST_F;
    tr_local = tr_slow ? tr_frame_q - FAST_F : tr_frame_q;
  end

  assign lk_vld_o  = lk_vld_q;
  assign lk_page_o = lk_page_q;
  assign tr_vld_o  = tr_vld_q;
  assign tr_page_o = tr_page_q;

endmodule

// File: rtl/psu_rate_limiter.sv
module psu_rate_limiter #(
  parameter int REFILL_CYCLES = 64,
  parameter int TOKEN_MAX     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic avail_o
);

  localparam int CNT_W = (REFILL_CYCLES > 1) ? $clog2(REFILL_CYCLES) : 1;
  localparam int TOK_W = $clog2(TOKEN_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REFILL_CYCLES - 1);
  localparam logic [TOK_W-1:0] TOK_TOP  = TOK_W'(TOKEN_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [TOK_W-1:0] tok_q;
  logic             refill;

  assign refill  = cnt_q == CNT_LAST;
  assign avail_o = tok_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tok_q <= '0;
    end else begin
      cnt_q <= refill ? '0 : cnt_q + CNT_W'(1);
      if (refill && take_i) begin
        if (tok_q == TOK_TOP) tok_q <= TOK_TOP - TOK_W'(1);
      end else if (refill) begin
        if (tok_q != TOK_TOP) tok_q <= tok_q + TOK_W'(1);
      end else if (take_i) begin
        tok_q <= tok_q - TOK_W'(1);
      end
    end
  end

  AST_TOKEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_q <= TOK_TOP); // R7

  AST_TAKE_NEEDS_TOKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> tok_q != '0); // R7

  AST_TOKEN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> tok_q >= $past(tok_q)); // R7

endmodule

// File: rtl/psu_swap_fsm.sv
module psu_swap_fsm
  import psu_pkg::*;
#(
  parameter int PAGE_W     = 3,
  parameter int FAST_PAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swp_valid_i,
  input  logic [PAGE_W-1:0] swp_hot_i,
  input  logic [PAGE_W-1:0] swp_cold_i,
  output logic              swp_ready_o,
  output logic [PAGE_W-1:0] hot_page_o,
  output logic [PAGE_W-1:0] cold_page_o,
  input  logic [PAGE_W-1:0] hot_frame_i,
  input  logic [PAGE_W-1:0] cold_frame_i,
  input  logic              hazard_i,
  input  logic              tok_avail_i,
  output logic              tok_take_o,
  output logic              cp_req_o,
  output logic [PAGE_W:0]   cp_src_o,
  output logic [PAGE_W:0]   cp_dst_o,
  input  logic              cp_done_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic [PAGE_W-1:0] hot_new_frame_o,
  output logic [PAGE_W-1:0] cold_new_frame_o
);

  localparam logic [PAGE_W-1:0] FAST_F = PAGE_W'(FAST_PAGES);
  localparam logic [PAGE_W:0]   STG_EP = {1'b1, {PAGE_W{1'b0}}};

  swap_state_e       state_q, state_d;
  logic [PAGE_W-1:0] hot_q, cold_q, hf_q, cf_q;
  logic              eligible;

  assign eligible   = (hot_frame_i >= FAST_F) && (cold_frame_i < FAST_F);
  assign tok_take_o = (state_q == SW_WAIT) && tok_avail_i && !hazard_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SW_IDLE:    if (swp_valid_i) state_d = SW_CHECK;
      SW_CHECK:   state_d = eligible ? SW_WAIT : SW_IDLE;
      SW_WAIT:    if (tok_take_o) state_d = SW_CP_HOT;
      SW_CP_HOT:  if (cp_done_i) state_d = SW_CP_COLD;
      SW_CP_COLD: if (cp_done_i) state_d = SW_CP_STG;
      SW_CP_STG:  if (cp_done_i) state_d = SW_COMMIT;
      SW_COMMIT:  state_d = SW_IDLE;
      default:    state_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SW_IDLE;
      hot_q   <= '0;
      cold_q  <= '0;
      hf_q    <= '0;
      cf_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SW_IDLE && swp_valid_i) begin
        hot_q  <= swp_hot_i;
        cold_q <= swp_cold_i;
      end
      if (state_q == SW_CHECK) begin
        hf_q <= hot_frame_i;
        cf_q <= cold_frame_i;
      end
    end
  end

  always_comb begin
    cp_req_o = 1'b0;
    cp_src_o = '0;
    cp_dst_o = '0;
    unique case (state_q)
      SW_CP_HOT: begin
        cp_req_o = 1'b1;
        cp_src_o = {1'b0, hf_q};
        cp_dst_o = STG_EP;
      end
      SW_CP_COLD: begin
        cp_req_o = 1'b1;
        cp_src_o = {1'b0, cf_q};
        cp_dst_o = {1'b0, hf_q};
      end
      SW_CP_STG: begin
        cp_req_o = 1'b1;
        cp_src_o = STG_EP;
        cp_dst_o = {1'b0, cf_q};
      end
      default: ;
    endcase
  end

  assign swp_ready_o      = state_q == SW_IDLE;
  assign busy_o           = state_q != SW_IDLE;
  assign hot_page_o       = hot_q;
  assign cold_page_o      = cold_q;
  assign commit_o         = state_q == SW_COMMIT;
  assign hot_new_frame_o  = cf_q;
  assign cold_new_frame_o = hf_q;

  AST_CP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_req_o && !cp_done_i |=> cp_req_o && $stable(cp_src_o) && $stable(cp_dst_o)); // R8

  AST_CROSS_TIER_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_req_o |-> (hf_q >= FAST_F) && (cf_q < FAST_F)); // R3

  AST_COMMIT_AFTER_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(cp_req_o && cp_done_i && cp_src_o == STG_EP)); // R5

endmodule

// File: rtl/page_swap_unit.sv
module page_swap_unit #(
  parameter int NUM_PAGES     = 8,
  parameter int FAST_PAGES    = 4,
  parameter int OFF_W         = 6,
  parameter int REFILL_CYCLES = 64,
  parameter int TOKEN_MAX     = 2
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     req_valid_i,
  output logic                                     req_ready_o,
  input  logic [$clog2(NUM_PAGES)-1:0]             req_page_i,
  input  logic [OFF_W-1:0]                         req_off_i,
  output logic                                     mem_valid_o,
  output logic                                     mem_slow_o,
  output logic [$clog2(NUM_PAGES)+OFF_W-1:0]       mem_addr_o,
  input  logic                                     swp_valid_i,
  output logic                                     swp_ready_o,
  input  logic [$clog2(NUM_PAGES)-1:0]             swp_hot_i,
  input  logic [$clog2(NUM_PAGES)-1:0]             swp_cold_i,
  output logic                                     cp_req_o,
  output logic [$clog2(NUM_PAGES):0]               cp_src_o,
  output logic [$clog2(NUM_PAGES):0]               cp_dst_o,
  input  logic                                     cp_done_i
);

  localparam int PAGE_W   = $clog2(NUM_PAGES);
  localparam int RD_PORTS = 3;

  logic                            acc;
  logic                            busy, commit, hazard, tok_avail, tok_take;
  logic [PAGE_W-1:0]               hot_page, cold_page, hot_new, cold_new;
  logic                            lk_vld, tr_vld;
  logic [PAGE_W-1:0]               lk_page, tr_page;
  logic [RD_PORTS-1:0][PAGE_W-1:0] rd_page, rd_frame;

  assign req_ready_o = !(busy && (req_page_i == hot_page || req_page_i == cold_page));
  assign acc         = req_valid_i && req_ready_o;

  assign rd_page[0] = lk_page;
  assign rd_page[1] = hot_page;
  assign rd_page[2] = cold_page;

  assign hazard = (lk_vld && (lk_page == hot_page || lk_page == cold_page)) ||
                  (tr_vld && (tr_page == hot_page || tr_page == cold_page));

  psu_remap_table #(
    .NUM_PAGES (NUM_PAGES),
    .PAGE_W    (PAGE_W),
    .RD_PORTS  (RD_PORTS)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_page_i    (rd_page),
    .rd_frame_o   (rd_frame),
    .wr_en_i      (commit),
    .wr_page_a_i  (hot_page),
    .wr_frame_a_i (hot_new),
    .wr_page_b_i  (cold_page),
    .wr_frame_b_i (cold_new)
  );

  psu_req_pipe #(
    .PAGE_W     (PAGE_W),
    .OFF_W      (OFF_W),
    .FAST_PAGES (FAST_PAGES)
  ) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .page_i      (req_page_i),
    .off_i       (req_off_i),
    .lk_vld_o    (lk_vld),
    .lk_page_o   (lk_page),
    .lk_frame_i  (rd_frame[0]),
    .tr_vld_o    (tr_vld),
    .tr_page_o   (tr_page),
    .mem_valid_o (mem_valid_o),
    .mem_slow_o  (mem_slow_o),
    .mem_addr_o  (mem_addr_o)
  );

  psu_rate_limiter #(
    .REFILL_CYCLES (REFILL_CYCLES),
    .TOKEN_MAX     (TOKEN_MAX)
  ) u_limiter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (tok_take),
    .avail_o (tok_avail)
  );

  psu_swap_fsm #(
    .PAGE_W     (PAGE_W),
    .FAST_PAGES (FAST_PAGES)
  ) u_swap (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .swp_valid_i      (swp_valid_i),
    .swp_hot_i        (swp_hot_i),
    .swp_cold_i       (swp_cold_i),
    .swp_ready_o      (swp_ready_o),
    .hot_page_o       (hot_page),
    .cold_page_o      (cold_page),
    .hot_frame_i      (rd_frame[1]),
    .cold_frame_i     (rd_frame[2]),
    .hazard_i         (hazard),
    .tok_avail_i      (tok_avail),
    .tok_take_o       (tok_take),
    .cp_req_o         (cp_req_o),
    .cp_src_o         (cp_src_o),
    .cp_dst_o         (cp_dst_o),
    .cp_done_i        (cp_done_i),
    .busy_o           (busy),
    .commit_o         (commit),
    .hot_new_frame_o  (hot_new),
    .cold_new_frame_o (cold_new)
  );

  AST_REQ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |-> ##3 mem_valid_o); // R2

  AST_PIPE_CLEAR_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_req_o |-> !(lk_vld && (lk_page == hot_page || lk_page == cold_page))); // R9

  AST_NO_PAIR_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_req_o |=> !(lk_vld && (lk_page == hot_page || lk_page == cold_page))); // R6

endmodule

// File: tb/page_swap_unit_bench.sv
`timescale 1ns/1ps
module page_swap_unit_bench;

  localparam int NP     = 8;
  localparam int FP     = 4;
  localparam int OW     = 6;
  localparam int REFILL = 100;
  localparam int PW     = 3;
  localparam int STG    = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_ready_o;
  logic [PW-1:0] req_page_i = '0;
  logic [OW-1:0] req_off_i = '0;
  logic mem_valid_o, mem_slow_o;
  logic [PW+OW-1:0] mem_addr_o;
  logic swp_valid_i = 1'b0;
  logic swp_ready_o;
  logic [PW-1:0] swp_hot_i = '0, swp_cold_i = '0;
  logic cp_req_o;
  logic [PW:0] cp_src_o, cp_dst_o;
  logic cp_done_i = 1'b0;

  always #4 clk = ~clk;

  page_swap_unit #(.REFILL_CYCLES(REFILL)) u_page_swap_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_page_i(req_page_i), .req_off_i(req_off_i),
    .mem_valid_o(mem_valid_o), .mem_slow_o(mem_slow_o), .mem_addr_o(mem_addr_o),
    .swp_valid_i(swp_valid_i), .swp_ready_o(swp_ready_o),
    .swp_hot_i(swp_hot_i), .swp_cold_i(swp_cold_i),
    .cp_req_o(cp_req_o), .cp_src_o(cp_src_o), .cp_dst_o(cp_dst_o),
    .cp_done_i(cp_done_i)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, copy_idx = 0;
  int exp_map [NP];
  int mem_q [$];
  int cp_q [$];
  int pend_q [$];
  int swap_start [$];

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_access(input int page, input int off);
    int f, loc, slow;
    f = exp_map[page];
    slow = (f >= FP) ? 1 : 0;
    loc = slow ? f - FP : f;
    return (slow << (PW + OW)) | (loc << OW) | off;
  endfunction

  // scoreboard monitor: R1/R2/R5 mapping and order
  always @(negedge clk) begin
    if (rst_ni && mem_valid_o) begin
      int act;
      act = {mem_slow_o, mem_addr_o};
      if (mem_q.size() == 0) check(0, "R2", "unexpected access", act, -1);
      else begin
        int e;
        e = mem_q.pop_front();
        check(act == e, "R2/R5", "access", act, e);
      end
    end
  end

  // copy engine model: R4 order, R8 stability, mapping update at third completion
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && cp_req_o) begin
        int s, d;
        s = cp_src_o; d = cp_dst_o;
        if (copy_idx % 3 == 0) swap_start.push_back(cyc);
        if (cp_q.size() < 2) check(0, "R4", "unexpected copy", s, -1);
        else begin
          int es, ed;
          es = cp_q.pop_front(); ed = cp_q.pop_front();
          check(s == es, "R4", "copy source", s, es);
          check(d == ed, "R4", "copy destination", d, ed);
        end
        @(negedge clk);
        check(cp_req_o && cp_src_o == s && cp_dst_o == d, "R8", "copy request held", cp_src_o, s);
        cp_done_i = 1'b1;
        @(negedge clk);
        cp_done_i = 1'b0;
        copy_idx++;
        if (copy_idx % 3 == 0 && pend_q.size() >= 2) begin
          int h, c, t;
          h = pend_q.pop_front(); c = pend_q.pop_front();
          t = exp_map[h]; exp_map[h] = exp_map[c]; exp_map[c] = t;
        end
      end
    end
  end

  task automatic send_req(input int page, input int off);
    @(negedge clk);
    req_valid_i = 1'b1; req_page_i = page[PW-1:0]; req_off_i = off[OW-1:0];
    #1;
    while (!req_ready_o) begin
      @(negedge clk); #1;
    end
    mem_q.push_back(exp_access(page, off));
    @(posedge clk); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic do_swap(input int hot, input int cold, input bit elig);
    if (elig) begin
      int hf, cf;
      hf = exp_map[hot]; cf = exp_map[cold];
      cp_q.push_back(hf); cp_q.push_back(STG);
      cp_q.push_back(cf); cp_q.push_back(hf);
      cp_q.push_back(STG); cp_q.push_back(cf);
      pend_q.push_back(hot); pend_q.push_back(cold);
    end
    @(negedge clk);
    swp_valid_i = 1'b1; swp_hot_i = hot[PW-1:0]; swp_cold_i = cold[PW-1:0];
    #1;
    while (!swp_ready_o) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    swp_valid_i = 1'b0;
  endtask

  task automatic wait_copies(input int target);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!(copy_idx >= target && swp_ready_o) && guard < 2000);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NP; i++) exp_map[i] = i;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check(mem_valid_o == 1'b0, "R2", "mem_valid after reset", mem_valid_o, 0);
    check(cp_req_o == 1'b0, "R7", "cp_req after reset", cp_req_o, 0);
    check(swp_ready_o == 1'b1, "R3", "swp_ready after reset", swp_ready_o, 1);
    check(req_ready_o == 1'b1, "R6", "req_ready after reset", req_ready_o, 1);

    // R2: exact latency
    @(negedge clk);
    req_valid_i = 1'b1; req_page_i = 3'd6; req_off_i = 6'd17;
    mem_q.push_back(exp_access(6, 17));
    @(posedge clk); #1; req_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(mem_valid_o == 1'b0, "R2", "no output before third edge", mem_valid_o, 0);
    @(negedge clk);
    check(mem_valid_o == 1'b1, "R2", "output after third edge", mem_valid_o, 1);

    // R1: identity mapping, back-to-back
    for (int p = 0; p < NP; p++) send_req(p, p * 5 + 1);
    repeat (4) @(negedge clk);

    // R7: bucket empty after reset, swap waits for first refill
    do_swap(5, 2, 1);
    while (cyc < REFILL - 5) @(negedge clk);
    check(cp_req_o == 1'b0, "R7", "copy before first token", cp_req_o, 0);
    wait_copies(3);
    check(swap_start.size() == 1 && swap_start[0] >= REFILL, "R7", "first swap start cycle",
          swap_start.size() > 0 ? swap_start[0] : -1, REFILL);
    send_req(5, 3);
    send_req(2, 4);

    // R6: stall pair pages during a swap, bystander passes
    do_swap(7, 0, 1);
    while (!cp_req_o) @(negedge clk);
    req_valid_i = 1'b1; req_page_i = 3'd7; #1;
    check(req_ready_o == 1'b0, "R6", "hot page ready during swap", req_ready_o, 0);
    req_page_i = 3'd0; #1;
    check(req_ready_o == 1'b0, "R6", "cold page ready during swap", req_ready_o, 0);
    req_page_i = 3'd3; #1;
    check(req_ready_o == 1'b1, "R6", "other page ready during swap", req_ready_o, 1);
    req_valid_i = 1'b0;
    send_req(3, 9);
    send_req(7, 11);
    check(copy_idx == 6, "R6", "hot page held until commit", copy_idx, 6);
    send_req(0, 12);
    wait_copies(6);

    // R3: discard ineligible pairs while a token is available
    while (cyc < 3 * REFILL + 10) @(negedge clk);
    begin
      bit seen = 0;
      do_swap(7, 0, 0);
      do_swap(1, 3, 0);
      @(negedge clk);
      @(negedge clk);
      check(swp_ready_o == 1'b1, "R3", "ready after discard", swp_ready_o, 1);
      repeat (20) begin
        @(negedge clk);
        if (cp_req_o) seen = 1;
      end
      check(seen == 0, "R3", "copy for discarded pair", seen, 0);
    end
    send_req(1, 2);
    send_req(7, 2);

    // R7: cap of two tokens
    while (!(cyc >= 6 * REFILL + 10 && cyc % REFILL == 10)) @(negedge clk);
    begin
      int c0;
      c0 = cyc;
      do_swap(4, 1, 1);
      do_swap(6, 3, 1);
      do_swap(2, 5, 1);
      wait_copies(15);
      check(swap_start.size() == 5, "R7", "swap count", swap_start.size(), 5);
      if (swap_start.size() == 5) begin
        check(swap_start[2] - c0 < 60, "R7", "first capped swap delay", swap_start[2] - c0, 0);
        check(swap_start[3] - c0 < 60, "R7", "second capped swap delay", swap_start[3] - c0, 0);
        check(swap_start[4] - c0 >= 85, "R7", "third swap waits refill", swap_start[4] - c0, 90);
      end
    end

    // R5: full mapping after all exchanges
    for (int p = 0; p < NP; p++) send_req(p, 63 - p);
    repeat (6) @(negedge clk);
    check(mem_q.size() == 0, "R2", "outstanding accesses", mem_q.size(), 0);
    check(cp_q.size() == 0, "R4", "outstanding copies", cp_q.size(), 0);
    finish_run();
  end

endmodule